// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block runs a time-aware gate control list for one egress port that has eight traffic-class gates. Software loads a short list of entries through a write port. Each entry holds an 8-bit mask of open gates and a hold time in nanoseconds. Software also supplies an absolute start time and the total cycle length. Once enabled, the block compares a shared free-running nanosecond counter with its next event time. It steps through the list in order and wraps back to the first entry at the end. At every step it presents the entry's mask to the queue selector.

Events are quantised to 200 ns slots. Durations, the cycle length and the start time must all be whole multiples of a slot. When that holds, two events fall in the same slot exactly when their times are equal. Several ports can share one schedule engine, so the block compares its own next event time with a neighbour's next event time and raises a flag when they collide. If the configuration is inconsistent, the block reports an error and holds every gate open. If the start time has already passed when the block is enabled, the schedule begins at the next whole cycle boundary counted from that start time.

Top module: `tgate_sched`

## Requirements
- R1: While reset is asserted, gate_open is 8'hFF, cur_entry is 0, and gate_evt, cfg_err and slot_clash are all 0.
- R2: While enable is low, or on any clock before the schedule start, gate_open is 8'hFF and cur_entry is 0. After enable falls, this holds from the next clock onward.
- R3: With a start time in the future, the first clock on which now_ns is at or past the start loads entry 0's mask into gate_open and sets cur_entry to 0.
- R4: Each later event fires on the first clock on which now_ns is at or past the start time plus the running sum of entry durations. The event applies the next entry's mask and index. After entry list_len-1 the list wraps to entry 0, so the schedule repeats every cycle_ns.
- R5: gate_evt is high for exactly the clocks on which gate_open and cur_entry take a scheduled update, and is low on every other clock.
- R6: If the start time is already in the past, the schedule begins at the smallest base_ns + k*cycle_ns (k a whole number) that is not earlier than the current time.
- R7: cfg_err goes high within two clocks of any of the following conditions. While cfg_err is high, gate_open is 8'hFF, cur_entry is 0 and no gate_evt occurs. The conditions are:
  - list_len is 0 or greater than 8;
  - an active entry has duration 0;
  - an active entry's duration, cycle_ns or base_ns is not a multiple of 200;
  - the sum of the active durations differs from cycle_ns.
- R8: slot_clash is high one clock after a clock on which all three of these hold:
  - the schedule is armed (waiting for its start or running);
  - peer_vld is high;
  - peer_evt_ns equals the block's own next event time.
  Otherwise slot_clash is low.
- R9: A write with wr_en high stores wr_mask and wr_dur into entry wr_addr. Entries at or beyond list_len take no part in the error check or the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the schedule when high |
| now_ns | input | 48 | Shared time counter in ns |
| base_ns | input | 48 | Absolute schedule start time in ns |
| cycle_ns | input | 32 | Cycle length in ns |
| list_len | input | 4 | Number of active entries |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 3 | Entry index to write |
| wr_mask | input | 8 | Gate-open mask for the entry |
| wr_dur | input | 32 | Entry duration in ns |
| peer_vld | input | 1 | Neighbour next-event time is valid |
| peer_evt_ns | input | 48 | Neighbour's next event time in ns |
| gate_open | output | 8 | Current gate-open mask, bit n for class n |
| cur_entry | output | 3 | Index of the entry in force |
| gate_evt | output | 1 | One-clock pulse on each gate event |
| cfg_err | output | 1 | Configuration is inconsistent |
| slot_clash | output | 1 | Own and neighbour event share a slot |

## Verification
If the next-event time register holds a wrong value, the error shows up at the ports on the clock of the next event. gate_evt fires early or late, and gate_open takes the new mask on the wrong clock. Every later event in the cycle keeps that offset, because each event time is the previous one plus a duration. A wrong entry index shows as the wrong mask on the very clock it is applied, and it also shifts every following duration. Misaligned past-start handling shows on the first event as a start that is off by a whole cycle or by part of one. A stale error flag shows within two clocks as gates that are forced open and events that stop.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } tg_state_e;

endpackage

// File: rtl/tgate_list.sv
module tgate_list #(
    parameter int NG   = 8,
    parameter int NE   = 8,
    parameter int DW   = 32,
    parameter int TW   = 48,
    parameter int SLOT = 200,
    localparam int IW  = $clog2(NE),
    localparam int LW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [NG-1:0] wr_mask,
    input  logic [DW-1:0] wr_dur,
    input  logic [LW-1:0] list_len,
    input  logic [DW-1:0] cycle_ns,
    input  logic [TW-1:0] base_ns,
    input  logic [IW-1:0] rd_idx,
    output logic [NG-1:0] rd_mask,
    output logic [DW-1:0] rd_dur,
    output logic          cfg_err
);

    localparam int SW = DW + LW;

    typedef struct packed {
        logic [NE-1:0][NG-1:0] mask;
        logic [NE-1:0][DW-1:0] dur;
        logic                  err;
    } lst_t;

    lst_t s_d, s_q;

    always_comb begin
        logic [SW-1:0] sum;
        logic          bad;
        s_d = s_q;
        if (wr_en) begin
            s_d.mask[wr_addr] = wr_mask;
            s_d.dur[wr_addr]  = wr_dur;
        end
        sum = '0;
        bad = 1'b0;
        for (int i = 0; i < NE; i++) begin
            if (LW'(i) < list_len) begin
                sum = sum + SW'(s_q.dur[i]);
                if (s_q.dur[i] == '0) bad = 1'b1;
                if ((s_q.dur[i] % DW'(SLOT)) != '0) bad = 1'b1;
            end
        end
        if (list_len == '0 || list_len > LW'(NE)) bad = 1'b1;
        if ((cycle_ns % DW'(SLOT)) != '0) bad = 1'b1;
        if ((base_ns % TW'(SLOT)) != '0) bad = 1'b1;
        if (sum != SW'(cycle_ns)) bad = 1'b1;
        s_d.err = bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_mask = s_q.mask[rd_idx];
    assign rd_dur  = s_q.dur[rd_idx];
    assign cfg_err = s_q.err;

endmodule

// File: rtl/tgate_seq.sv
module tgate_seq #(
    parameter int NG  = 8,
    parameter int NE  = 8,
    parameter int DW  = 32,
    parameter int TW  = 48,
    localparam int IW = $clog2(NE),
    localparam int LW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cfg_err,
    input  logic [TW-1:0] now_ns,
    input  logic [TW-1:0] base_ns,
    input  logic [DW-1:0] cycle_ns,
    input  logic [LW-1:0] list_len,
    input  logic [NG-1:0] ent_mask,
    input  logic [DW-1:0] ent_dur,
    output logic [IW-1:0] rd_idx,
    output logic [NG-1:0] gate_open,
    output logic [IW-1:0] cur_entry,
    output logic          gate_evt,
    output logic          armed,
    output logic [TW-1:0] next_ev
);
    import tgate_pkg::*;

    typedef struct packed {
        tg_state_e     st;
        logic [NG-1:0] gate;
        logic [IW-1:0] idx;
        logic          evt;
        logic [TW-1:0] nev;
    } seq_t;

    seq_t q_d, q_q;
    logic [IW-1:0] nxt;

    always_comb begin
        if (q_q.st == ST_WAIT || ({1'b0, q_q.idx} + LW'(1)) >= list_len)
            nxt = '0;
        else
            nxt = q_q.idx + IW'(1);
    end

    always_comb begin
        q_d     = q_q;
        q_d.evt = 1'b0;
        if (!enable || cfg_err) begin
            q_d.st   = ST_IDLE;
            q_d.gate = '1;
            q_d.idx  = '0;
        end else begin
            case (q_q.st)
                ST_IDLE: begin
                    q_d.st   = ST_ALIGN;
                    q_d.nev  = base_ns;
                    q_d.gate = '1;
                    q_d.idx  = '0;
                end
                ST_ALIGN: begin
                    if (q_q.nev < now_ns) q_d.nev = q_q.nev + TW'(cycle_ns);
                    else                  q_d.st  = ST_WAIT;
                end
                ST_WAIT, ST_RUN: begin
                    if (now_ns >= q_q.nev) begin
                        q_d.st   = ST_RUN;
                        q_d.gate = ent_mask;
                        q_d.idx  = nxt;
                        q_d.evt  = 1'b1;
                        q_d.nev  = q_q.nev + TW'(ent_dur);
                    end
                end
                default: q_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q.st   <= ST_IDLE;
            q_q.gate <= '1;
            q_q.idx  <= '0;
            q_q.evt  <= 1'b0;
            q_q.nev  <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign rd_idx    = nxt;
    assign gate_open = q_q.gate;
    assign cur_entry = q_q.idx;
    assign gate_evt  = q_q.evt;
    assign armed     = (q_q.st == ST_WAIT) || (q_q.st == ST_RUN);
    assign next_ev   = q_q.nev;

endmodule

// File: rtl/tgate_clash.sv
module tgate_clash #(
    parameter int TW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic [TW-1:0] own_ev,
    input  logic          peer_vld,
    input  logic [TW-1:0] peer_ev,
    output logic          clash
);

    logic clash_d, clash_q;

    always_comb begin
        clash_d = armed && peer_vld && (own_ev == peer_ev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) clash_q <= 1'b0;
        else        clash_q <= clash_d;
    end

    assign clash = clash_q;

endmodule

// File: rtl/tgate_sched.sv
module tgate_sched #(
    parameter int NG   = 8,
    parameter int NE   = 8,
    parameter int DW   = 32,
    parameter int TW   = 48,
    parameter int SLOT = 200,
    localparam int IW  = $clog2(NE),
    localparam int LW  = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] now_ns,
    input  logic [TW-1:0] base_ns,
    input  logic [DW-1:0] cycle_ns,
    input  logic [LW-1:0] list_len,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [NG-1:0] wr_mask,
    input  logic [DW-1:0] wr_dur,
    input  logic          peer_vld,
    input  logic [TW-1:0] peer_evt_ns,
    output logic [NG-1:0] gate_open,
    output logic [IW-1:0] cur_entry,
    output logic          gate_evt,
    output logic          cfg_err,
    output logic          slot_clash
);

    logic [IW-1:0] rd_idx;
    logic [NG-1:0] ent_mask;
    logic [DW-1:0] ent_dur;
    logic          armed;
    logic [TW-1:0] next_ev;

    tgate_list #(.NG(NG), .NE(NE), .DW(DW), .TW(TW), .SLOT(SLOT)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .wr_dur   (wr_dur),
        .list_len (list_len),
        .cycle_ns (cycle_ns),
        .base_ns  (base_ns),
        .rd_idx   (rd_idx),
        .rd_mask  (ent_mask),
        .rd_dur   (ent_dur),
        .cfg_err  (cfg_err)
    );

    tgate_seq #(.NG(NG), .NE(NE), .DW(DW), .TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_err   (cfg_err),
        .now_ns    (now_ns),
        .base_ns   (base_ns),
        .cycle_ns  (cycle_ns),
        .list_len  (list_len),
        .ent_mask  (ent_mask),
        .ent_dur   (ent_dur),
        .rd_idx    (rd_idx),
        .gate_open (gate_open),
        .cur_entry (cur_entry),
        .gate_evt  (gate_evt),
        .armed     (armed),
        .next_ev   (next_ev)
    );

    tgate_clash #(.TW(TW)) u_clash (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .own_ev   (next_ev),
        .peer_vld (peer_vld),
        .peer_ev  (peer_evt_ns),
        .clash    (slot_clash)
    );

endmodule

// File: rtl/tgate_sched_chk.sv
module tgate_sched_chk #(
    parameter int NG  = 8,
    parameter int NE  = 8,
    localparam int IW = $clog2(NE),
    localparam int LW = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [LW-1:0] list_len,
    input logic          peer_vld,
    input logic [NG-1:0] gate_open,
    input logic [IW-1:0] cur_entry,
    input logic          gate_evt,
    input logic          cfg_err,
    input logic          slot_clash
);

    // R2
    disabled_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_open == '1 && cur_entry == '0 && !gate_evt));

    // R7
    cfg_err_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (gate_open == '1 && !gate_evt));

    // R5
    entry_move_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_entry) && $past(enable) && !$past(cfg_err)) |-> gate_evt);

    // R5
    evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |-> $past(enable));

    // R4
    evt_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |-> ({1'b0, cur_entry} < list_len));

    // R8
    clash_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_clash |-> $past(peer_vld));

endmodule

bind tgate_sched tgate_sched_chk #(.NG(NG), .NE(NE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .list_len   (list_len),
    .peer_vld   (peer_vld),
    .gate_open  (gate_open),
    .cur_entry  (cur_entry),
    .gate_evt   (gate_evt),
    .cfg_err    (cfg_err),
    .slot_clash (slot_clash)
);

// File: tb/tgate_sched_test.sv
`timescale 1ns/1ps
module tgate_sched_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [47:0] now_ns = '0;
    logic [47:0] base_ns = '0;
    logic [31:0] cycle_ns = '0;
    logic [3:0]  list_len = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_mask = '0;
    logic [31:0] wr_dur = '0;
    logic        peer_vld = 1'b0;
    logic [47:0] peer_evt_ns = '0;
    logic [7:0]  gate_open;
    logic [2:0]  cur_entry;
    logic        gate_evt;
    logic        cfg_err;
    logic        slot_clash;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] bm [8];
    longint     bd [8];
    int         blen;
    longint     bcyc;
    longint     bstart;

    tgate_sched uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .now_ns      (now_ns),
        .base_ns     (base_ns),
        .cycle_ns    (cycle_ns),
        .list_len    (list_len),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_mask     (wr_mask),
        .wr_dur      (wr_dur),
        .peer_vld    (peer_vld),
        .peer_evt_ns (peer_evt_ns),
        .gate_open   (gate_open),
        .cur_entry   (cur_entry),
        .gate_evt    (gate_evt),
        .cfg_err     (cfg_err),
        .slot_clash  (slot_clash)
    );

    always #2 clk = ~clk;
    always @(posedge clk) now_ns <= now_ns + 48'd4;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_ent(input int a, input logic [7:0] m, input longint d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_mask = m; wr_dur = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load();
        for (int i = 0; i < blen; i++) wr_ent(i, bm[i], bd[i]);
        list_len = 4'(blen);
        cycle_ns = 32'(bcyc);
    endtask

    task automatic model(input longint t, output int idx, output logic [7:0] m);
        longint ph, acc;
        idx = 0; m = 8'hFF;
        if (t >= bstart) begin
            ph = (t - bstart) % bcyc;
            acc = 0;
            for (int i = 0; i < blen; i++) begin
                if (ph >= acc && ph < acc + bd[i]) begin idx = i; m = bm[i]; end
                acc += bd[i];
            end
        end
    endtask

    task automatic run_check(input int n, input string req);
        longint t;
        int i0, i1;
        logic [7:0] m0, m1;
        logic pe;
        repeat (n) begin
            @(negedge clk);
            t = longint'(now_ns) - 4;
            model(t, i1, m1);
            model(t - 4, i0, m0);
            pe = (t >= bstart) && ((t - 4 < bstart) || (i0 != i1));
            chk({req, " gate"}, 64'(gate_open), 64'(m1));
            chk({req, " idx"}, 64'(cur_entry), 64'(i1));
            chk({req, " pulse"}, 64'(gate_evt), 64'(pe));
        end
    endtask

    task automatic future_start(input longint slots);
        @(negedge clk);
        bstart = ((longint'(now_ns) / 200) + slots) * 200;
        base_ns = 48'(bstart);
        enable = 1'b1;
    endtask

    task automatic disable_check();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        repeat (10) begin
            @(negedge clk);
            // R2: disabled means all gates open, entry 0, no pulse
            chk("R2 off gate", 64'(gate_open), 64'hFF);
            chk("R2 off idx", 64'(cur_entry), 64'd0);
            chk("R2 off pulse", 64'(gate_evt), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 gate", 64'(gate_open), 64'hFF);
        chk("R1 idx", 64'(cur_entry), 64'd0);
        chk("R1 evt", 64'(gate_evt), 64'd0);
        chk("R1 err", 64'(cfg_err), 64'd0);
        chk("R1 clash", 64'(slot_clash), 64'd0);
        rst_n = 1'b1;

        // Schedule A: class 7 for 200 ns then classes 0-6 for 800 ns
        blen = 2; bcyc = 1000;
        bm[0] = 8'h80; bd[0] = 200;
        bm[1] = 8'h7F; bd[1] = 800;
        load();
        // R9: an inactive entry with zero duration is ignored
        wr_ent(5, 8'h55, 0);
        repeat (3) @(negedge clk);
        chk("R9 inactive entry", 64'(cfg_err), 64'd0);

        // R3 R4 R5: future start, wrap over several cycles
        future_start(6);
        run_check(1600, "R3/R4/R5 schedA");
        disable_check();

        // R7: error cases with enable held high
        enable = 1'b1;
        base_ns = 48'd0;
        wr_ent(1, 8'h7F, 0);
        repeat (3) @(negedge clk);
        chk("R7 zero dur", 64'(cfg_err), 64'd1);
        repeat (10) begin
            @(negedge clk);
            chk("R7 err gate", 64'(gate_open), 64'hFF);
            chk("R7 err pulse", 64'(gate_evt), 64'd0);
        end
        wr_ent(1, 8'h7F, 250); cycle_ns = 32'd450;
        repeat (3) @(negedge clk);
        chk("R7 misaligned dur", 64'(cfg_err), 64'd1);
        wr_ent(1, 8'h7F, 800); cycle_ns = 32'd1000;
        repeat (3) @(negedge clk);
        chk("R7 restored", 64'(cfg_err), 64'd0);
        cycle_ns = 32'd1200;
        repeat (3) @(negedge clk);
        chk("R7 sum mismatch", 64'(cfg_err), 64'd1);
        cycle_ns = 32'd1000; list_len = 4'd0;
        repeat (3) @(negedge clk);
        chk("R7 empty list", 64'(cfg_err), 64'd1);
        list_len = 4'd9;
        repeat (3) @(negedge clk);
        chk("R7 list too long", 64'(cfg_err), 64'd1);
        list_len = 4'd2; base_ns = 48'd1001;
        repeat (3) @(negedge clk);
        chk("R7 misaligned base", 64'(cfg_err), 64'd1);
        enable = 1'b0; base_ns = 48'd0;
        repeat (3) @(negedge clk);
        chk("R7 cleared", 64'(cfg_err), 64'd0);

        // R8: collision with a neighbour's next event time
        future_start(200);
        repeat (5) @(negedge clk);
        peer_vld = 1'b1; peer_evt_ns = 48'(bstart);
        repeat (3) @(negedge clk);
        chk("R8 same slot", 64'(slot_clash), 64'd1);
        peer_evt_ns = 48'(bstart + 200);
        repeat (3) @(negedge clk);
        chk("R8 next slot", 64'(slot_clash), 64'd0);
        peer_evt_ns = 48'(bstart); peer_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 peer invalid", 64'(slot_clash), 64'd0);
        disable_check();

        // Schedule B with a start time in the past (R6)
        blen = 4; bcyc = 1400;
        bm[0] = 8'h01; bd[0] = 200;
        bm[1] = 8'h06; bd[1] = 400;
        bm[2] = 8'hF0; bd[2] = 200;
        bm[3] = 8'h00; bd[3] = 600;
        load();
        base_ns = 48'd200;
        @(negedge clk);
        while (((longint'(now_ns) - 200) % bcyc) < 300 || ((longint'(now_ns) - 200) % bcyc) > 700)
            @(negedge clk);
        bstart = 200 + ((longint'(now_ns) - 200) / bcyc + 1) * bcyc;
        enable = 1'b1;
        run_check(2000, "R6/R4 schedB");
        disable_check();

        // Schedule C: all eight entries, one gate each
        blen = 8; bcyc = 1600;
        for (int i = 0; i < 8; i++) begin bm[i] = 8'(1 << i); bd[i] = 200; end
        load();
        future_start(3);
        run_check(2000, "R4/R5 schedC");
        disable_check();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule